// File: doc/BRIEF.md
# Split Completion Return Sequencer

This block answers one outstanding non-posted request from a PCI-X-style requester. It answers at once with a split response. It then returns the result later as a sequence of split completion segments on a valid/ready output. For a read, the block tracks how many completion bytes an upstream fill interface has placed in the buffer. It cuts the read into data segments that start and end on 128-byte allowable disconnect boundaries (ADBs). When enough data is already buffered, one segment may cover several ADBs. For a write, one completion event produces a single status message.

At acceptance, the read length is clipped to the valid device range. The bytes before the range limit are returned as normal data. The bytes past the limit are then reported as a master-abort error message. A programmable completion timer starts when the request is accepted. If it expires while the block is still waiting for data, the pending request is dropped and everything still owed is reported as a master-abort error message. Every segment carries its start address, its byte count, the bytes still owed after it, a last flag, a status code and the requester tag.

Top module: `split_cpl_seq`

## Requirements
- R1: After reset, req_ready is 1, seg_valid is 0 and split_rsp is 0.
- R2: A request is taken on a cycle with req_valid and req_ready both 1. On the following cycle split_rsp is 1 for exactly one cycle. req_ready stays 0 until the segment with seg_last set has been granted, and it is 1 one cycle after that grant.
- R3: A write request (req_write=1) presents nothing until a fill_valid pulse arrives. It then presents exactly one segment: status 1 (normal message), 0 bytes, remain 0, last 1, with the request's address and tag.
- R4: A read data segment (status 0) is presented only when the buffered byte count covers its full length. When the buffered bytes cover all in-range bytes still owed, one segment carries all of them, even if that is more than 128 bytes.
- R5: Otherwise a data segment ends on the highest 128-byte boundary that the buffered bytes reach. If the buffered bytes do not reach the next boundary, no segment is presented.
- R6: seg_addr is the address of the segment's first byte. seg_remain is the count still owed after this segment. seg_last is 1 exactly when seg_remain is 0. seg_tag is the request's tag.
- R7: While seg_valid is 1 and seg_ready is 0, the segment's fields stay unchanged and seg_valid stays 1.
- R8: For a read whose bytes run past range_end (the first out-of-range address), the in-range bytes are returned as data segments. A status 2 (master-abort error) message then follows at the first out-of-range address, carrying the out-of-range byte count, with remain 0 and last 1.
- R9: A read whose start address is at or beyond range_end returns no data. The status 2 message with the full byte count is presented two cycles after acceptance.
- R10: If tmo_limit cycles pass after acceptance while the block is still waiting to start a segment, the segment presented next, tmo_limit+1 cycles after the acceptance edge, is a status 2 message. It carries all bytes still owed, with remain 0 and last 1. Fills arriving after that have no effect.
- R11: Fill pulses while idle are discarded. The buffered byte count is cleared when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A new request is offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 for a write (status only), 0 for a read |
| req_addr | input | ADDR_W | Start address of the request |
| req_bytes | input | CNT_W | Requested byte count |
| req_tag | input | TAG_W | Requester tag echoed on every segment |
| range_end | input | ADDR_W | First address outside the valid device range |
| tmo_limit | input | TMO_W | Completion timeout in cycles |
| split_rsp | output | 1 | One-cycle split response for an accepted request |
| fill_valid | input | 1 | Upstream completion bytes arrive this cycle |
| fill_bytes | input | CNT_W | Number of bytes arriving |
| seg_valid | output | 1 | A split completion segment is presented |
| seg_ready | input | 1 | Grant for the presented segment |
| seg_addr | output | ADDR_W | Address of the segment's first byte |
| seg_bytes | output | CNT_W | Bytes in this segment |
| seg_remain | output | CNT_W | Bytes still owed after this segment |
| seg_last | output | 1 | Final segment of the request |
| seg_status | output | 2 | 0 data, 1 normal message, 2 master-abort error |
| seg_tag | output | TAG_W | Tag of the request |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 13-bit byte counts, a 5-bit tag, a 12-bit timer and 128-byte ADBs. The 13-bit count allows requests of several hundred bytes, so merged segments of more than one ADB, misaligned starts and boundary waits all occur within a few fills. The 12-bit timer lets the bench program limits of 20 to 30 cycles, so the expiry cycle is checked exactly and the bench also confirms that the block stays silent in the cycle before expiry.

// File: rtl/split_cpl_pkg.sv
package split_cpl_pkg;

  typedef enum logic [1:0] {
    CPL_DATA   = 2'd0,
    CPL_MSG_OK = 2'd1,
    CPL_MSG_MA = 2'd2
  } cpl_status_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_SEND = 2'd2
  } phase_e;

  // Bytes of a request that fall below the range limit.
  function automatic logic [31:0] in_range_len(input logic [31:0] addr,
                                               input logic [31:0] bytes,
                                               input logic [31:0] lim);
    logic [31:0] span;
    if (addr >= lim) return 32'd0;
    span = lim - addr;
    return (bytes < span) ? bytes : span;
  endfunction

  // Segment length from current address, bytes owed and bytes buffered.
  function automatic logic [31:0] seg_len(input logic [31:0] addr,
                                          input logic [31:0] remain,
                                          input logic [31:0] avail,
                                          input logic [31:0] adb);
    logic [31:0] to_bnd;
    to_bnd = adb - (addr % adb);
    if (avail >= remain) return remain;
    if (avail < to_bnd) return 32'd0;
    return to_bnd + ((avail - to_bnd) / adb) * adb;
  endfunction

endpackage

// File: rtl/split_cpl_timer.sv
module split_cpl_timer #(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (start)             cnt <= '0;
    else if (run && cnt != '1)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);
endmodule

// File: rtl/split_cpl_occ.sv
module split_cpl_occ #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_bytes,
  input  logic             sub_en,
  input  logic [CNT_W-1:0] sub_bytes,
  output logic [CNT_W:0]   occ
);
  logic [CNT_W:0] base, add_v, sub_v;

  always_comb begin
    base  = clear  ? '0 : occ;
    add_v = add_en ? {1'b0, add_bytes} : '0;
    sub_v = sub_en ? {1'b0, sub_bytes} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= base + add_v - sub_v;
  end
endmodule

// File: rtl/split_cpl_segsize.sv
module split_cpl_segsize
  import split_cpl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 13,
  parameter int ADB_BYTES = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  remain,
  input  logic [CNT_W:0]    avail,
  output logic [CNT_W-1:0]  len
);
  always_comb
    len = CNT_W'(seg_len(32'(addr), 32'(remain), 32'(avail), 32'(ADB_BYTES)));
endmodule

// File: rtl/split_cpl_seq.sv
module split_cpl_seq
  import split_cpl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 13,
  parameter int TAG_W     = 5,
  parameter int TMO_W     = 12,
  parameter int ADB_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ADDR_W-1:0] range_end,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              split_rsp,
  input  logic              fill_valid,
  input  logic [CNT_W-1:0]  fill_bytes,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [CNT_W-1:0]  seg_bytes,
  output logic [CNT_W-1:0]  seg_remain,
  output logic              seg_last,
  output logic [1:0]        seg_status,
  output logic [TAG_W-1:0]  seg_tag
);
  localparam int OCC_W = CNT_W + 1;

  phase_e            phase;
  logic              is_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  rem_good;
  logic [CNT_W-1:0]  rem_total;
  logic [TAG_W-1:0]  tag_q;
  logic              split_rsp_q;

  logic [ADDR_W-1:0] seg_addr_q;
  logic [CNT_W-1:0]  seg_bytes_q;
  logic [CNT_W-1:0]  seg_remain_q;
  logic              seg_last_q;
  cpl_status_e       seg_status_q;

  // Named events for the checker
  logic             accept;
  logic             seg_fire;
  logic             consume;
  logic             tmo_fire;
  logic             range_err;
  logic             msg_go;
  logic             data_go;
  logic             expired;
  logic [OCC_W-1:0] occ;
  logic [CNT_W-1:0] next_len;
  logic [CNT_W-1:0] good_at_accept;

  assign req_ready = (phase == PH_IDLE);
  assign seg_valid = (phase == PH_SEND);
  assign accept    = req_valid && req_ready;
  assign seg_fire  = seg_valid && seg_ready;
  assign consume   = seg_fire && (seg_status_q == CPL_DATA);

  assign good_at_accept = req_write ? '0 :
    CNT_W'(in_range_len(32'(req_addr), 32'(req_bytes), 32'(range_end)));

  split_cpl_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .run(phase != PH_IDLE), .limit(tmo_limit), .expired(expired)
  );

  split_cpl_occ #(.CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .add_en(fill_valid && (phase != PH_IDLE) && !is_wr),
    .add_bytes(fill_bytes),
    .sub_en(consume), .sub_bytes(seg_bytes_q),
    .occ(occ)
  );

  split_cpl_segsize #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADB_BYTES(ADB_BYTES)) u_size (
    .addr(cur_addr), .remain(rem_good), .avail(occ), .len(next_len)
  );

  always_comb begin
    tmo_fire  = (phase == PH_WAIT) && expired;
    range_err = (phase == PH_WAIT) && !tmo_fire && !is_wr && (rem_good == '0);
    msg_go    = (phase == PH_WAIT) && !tmo_fire && is_wr && fill_valid;
    data_go   = (phase == PH_WAIT) && !tmo_fire && !is_wr &&
                (rem_good != '0) && (next_len != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      is_wr        <= 1'b0;
      cur_addr     <= '0;
      rem_good     <= '0;
      rem_total    <= '0;
      tag_q        <= '0;
      split_rsp_q  <= 1'b0;
      seg_addr_q   <= '0;
      seg_bytes_q  <= '0;
      seg_remain_q <= '0;
      seg_last_q   <= 1'b0;
      seg_status_q <= CPL_DATA;
    end else begin
      split_rsp_q <= accept;
      unique case (phase)
        PH_IDLE: if (accept) begin
          is_wr     <= req_write;
          cur_addr  <= req_addr;
          rem_total <= req_bytes;
          rem_good  <= good_at_accept;
          tag_q     <= req_tag;
          phase     <= PH_WAIT;
        end
        PH_WAIT: begin
          if (tmo_fire || range_err) begin
            seg_status_q <= CPL_MSG_MA;
            seg_addr_q   <= cur_addr;
            seg_bytes_q  <= rem_total;
            seg_remain_q <= '0;
            seg_last_q   <= 1'b1;
            phase        <= PH_SEND;
          end else if (msg_go) begin
            seg_status_q <= CPL_MSG_OK;
            seg_addr_q   <= cur_addr;
            seg_bytes_q  <= '0;
            seg_remain_q <= '0;
            seg_last_q   <= 1'b1;
            phase        <= PH_SEND;
          end else if (data_go) begin
            seg_status_q <= CPL_DATA;
            seg_addr_q   <= cur_addr;
            seg_bytes_q  <= next_len;
            seg_remain_q <= rem_total - next_len;
            seg_last_q   <= (rem_total == next_len);
            phase        <= PH_SEND;
          end
        end
        PH_SEND: if (seg_fire) begin
          if (seg_status_q == CPL_DATA) begin
            cur_addr  <= cur_addr + ADDR_W'(seg_bytes_q);
            rem_good  <= rem_good - seg_bytes_q;
            rem_total <= rem_total - seg_bytes_q;
            phase     <= (seg_remain_q == '0) ? PH_IDLE : PH_WAIT;
          end else begin
            rem_total <= '0;
            rem_good  <= '0;
            phase     <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign split_rsp  = split_rsp_q;
  assign seg_addr   = seg_addr_q;
  assign seg_bytes  = seg_bytes_q;
  assign seg_remain = seg_remain_q;
  assign seg_last   = seg_last_q;
  assign seg_status = seg_status_q;
  assign seg_tag    = tag_q;
endmodule

// File: rtl/split_cpl_seq_chk.sv
module split_cpl_seq_chk #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 13,
  parameter int ADB_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              split_rsp,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [CNT_W-1:0]  seg_bytes,
  input logic [CNT_W-1:0]  seg_remain,
  input logic              seg_last,
  input logic [1:0]        seg_status,
  input logic              accept,
  input logic              tmo_fire,
  input logic [CNT_W:0]    occ,
  input logic [CNT_W-1:0]  rem_good
);
  localparam int ADB_LSB = $clog2(ADB_BYTES);

  logic [ADDR_W-1:0] seg_end;
  assign seg_end = seg_addr + ADDR_W'(seg_bytes);

  // R2
  split_rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> split_rsp && !req_ready);

  // R7
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_bytes)
                               && $stable(seg_status) && $stable(seg_last) && $stable(seg_remain));

  // R6
  last_iff_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_last == (seg_remain == '0)));

  // R4
  data_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_status == 2'd0 |-> {1'b0, seg_bytes} <= occ);

  // R5
  adb_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_status == 2'd0 |-> (seg_end[ADB_LSB-1:0] == '0) || (seg_bytes == rem_good));

  // R10
  timeout_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> seg_valid && seg_status == 2'd2 && seg_last);
endmodule

bind split_cpl_seq split_cpl_seq_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADB_BYTES(ADB_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .split_rsp(split_rsp),
  .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
  .seg_bytes(seg_bytes), .seg_remain(seg_remain), .seg_last(seg_last),
  .seg_status(seg_status), .accept(accept), .tmo_fire(tmo_fire),
  .occ(occ), .rem_good(rem_good)
);

// File: tb/split_cpl_seq_test.sv
module split_cpl_seq_test;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 13;
  localparam int TAG_W  = 5;
  localparam int TMO_W  = 12;
  localparam int ADB    = 128;
  localparam int NVEC   = 6;

  // {addr, bytes, range_end, first fill, second fill}
  localparam int VEC [NVEC][5] = '{
    '{'h0000,  64, 'hF000,  64,   0},
    '{'h0040, 300, 'hF000, 100, 200},
    '{'h0000, 512, 'hF000, 300, 212},
    '{'h0020, 200, 'h0080,  50,  46},
    '{'h0010,  40, 'hF000,  40,   0},
    '{'h0070, 100, 'hF000,  30,  70}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_bytes = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic [ADDR_W-1:0] range_end = '0;
  logic [TMO_W-1:0]  tmo_limit = 12'd4000;
  logic              split_rsp;
  logic              fill_valid = 1'b0;
  logic [CNT_W-1:0]  fill_bytes = '0;
  logic              seg_valid;
  logic              seg_ready = 1'b1;
  logic [ADDR_W-1:0] seg_addr;
  logic [CNT_W-1:0]  seg_bytes;
  logic [CNT_W-1:0]  seg_remain;
  logic              seg_last;
  logic [1:0]        seg_status;
  logic [TAG_W-1:0]  seg_tag;

  int total = 0;
  int fails = 0;

  split_cpl_seq uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected cut: all owed bytes if buffered, else up to the last boundary reached.
  function automatic int cut_len(input int addr, input int owed, input int avail);
    int edge_a;
    if (avail >= owed) return owed;
    edge_a = ((addr + avail) / ADB) * ADB;
    return (edge_a > addr) ? edge_a - addr : 0;
  endfunction

  task automatic send_req(input bit wr, input int addr, input int bytes, input int lim, input int tag);
    req_valid = 1'b1; req_write = wr;
    req_addr = ADDR_W'(addr); req_bytes = CNT_W'(bytes);
    range_end = ADDR_W'(lim); req_tag = TAG_W'(tag);
    step();
    req_valid = 1'b0;
    chk(split_rsp == 1'b1, "R2 split_rsp", int'(split_rsp), 1);
    chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
  endtask

  task automatic fill(input int n);
    fill_valid = 1'b1; fill_bytes = CNT_W'(n);
    step();
    fill_valid = 1'b0;
  endtask

  task automatic take(input string tag, input int e_addr, input int e_bytes, input int e_rem,
                      input int e_st, input int e_tag);
    int n;
    n = 0;
    while (!seg_valid && n < 40) begin step(); n++; end
    chk(seg_valid == 1'b1, tag, int'(seg_valid), 1);
    chk(int'(seg_addr) == e_addr, tag, int'(seg_addr), e_addr);
    chk(int'(seg_bytes) == e_bytes, tag, int'(seg_bytes), e_bytes);
    chk(int'(seg_remain) == e_rem, tag, int'(seg_remain), e_rem);
    chk(seg_last == (e_rem == 0), tag, int'(seg_last), int'(e_rem == 0));
    chk(int'(seg_status) == e_st, tag, int'(seg_status), e_st);
    chk(int'(seg_tag) == e_tag, tag, int'(seg_tag), e_tag);
    step();
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin step(); if (seg_valid) seen = 1'b1; end
    chk(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    step(); step();
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(seg_valid == 1'b0, "R1 seg_valid", int'(seg_valid), 0);
    chk(split_rsp == 1'b0, "R1 split_rsp", int'(split_rsp), 0);
    rst_n = 1'b1;
    step();
    chk(req_ready == 1'b1 && !seg_valid, "R1 after release", int'(req_ready), 1);

    // Table of read patterns: R4, R5, R6, R8
    for (int v = 0; v < NVEC; v++) begin
      int a, b, lim, f1, f2, good, bad, rem, s1, left;
      a = VEC[v][0]; b = VEC[v][1]; lim = VEC[v][2]; f1 = VEC[v][3]; f2 = VEC[v][4];
      good = (a >= lim) ? 0 : ((b < lim - a) ? b : lim - a);
      bad  = b - good;
      rem  = b;
      send_req(1'b0, a, b, lim, v);
      fill(f1);
      s1 = cut_len(a, good, f1);
      left = good;
      if (s1 > 0) begin
        take("R4 R5 R6 first data", a, s1, rem - s1, 0, v);
        a += s1; rem -= s1; left -= s1;
      end else begin
        quiet(6, "R5 wait for boundary");
      end
      if (f2 > 0) begin
        fill(f2);
        take("R4 R6 merged data", a, left, rem - left, 0, v);
        a += left; rem -= left;
      end
      if (bad > 0) take("R8 range error", a, bad, 0, 2, v);
      step();
      chk(req_ready == 1'b1, "R2 ready after last", int'(req_ready), 1);
    end

    // R3: write status message
    send_req(1'b1, 'h200, 8, 'hF000, 5);
    quiet(4, "R3 no message before completion");
    fill(0);
    take("R3 write message", 'h200, 0, 0, 1, 5);
    step();
    chk(req_ready == 1'b1, "R3 ready", int'(req_ready), 1);

    // R7: hold while not granted
    seg_ready = 1'b0;
    send_req(1'b0, 'h300, 64, 'hF000, 7);
    fill(64);
    step(); step();
    chk(seg_valid == 1'b1, "R7 presented", int'(seg_valid), 1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(seg_valid && seg_addr == 16'h300 && seg_bytes == 13'd64, "R7 held",
          int'(seg_bytes), 64);
    end
    seg_ready = 1'b1;
    step(); step();
    chk(req_ready == 1'b1, "R7 released", int'(req_ready), 1);

    // R9: entirely out of range
    send_req(1'b0, 'h9000, 50, 'h8000, 9);
    chk(seg_valid == 1'b0, "R9 not before", int'(seg_valid), 0);
    step();
    chk(seg_valid == 1'b1, "R9 timing", int'(seg_valid), 1);
    take("R9 full error", 'h9000, 50, 0, 2, 9);

    // R11 + R10: idle fill discarded, then timeout exact cycle
    tmo_limit = 12'd20;
    fill(200);
    send_req(1'b0, 'h400, 64, 'hF000, 11);
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 20; k++) begin step(); if (seg_valid) seen = 1'b1; end
      chk(!seen, "R11 idle fill discarded", int'(seen), 0);
    end
    step();
    chk(seg_valid == 1'b1, "R10 expiry cycle", int'(seg_valid), 1);
    take("R10 timeout error", 'h400, 64, 0, 2, 11);

    // R10: timeout after partial delivery, later fill ignored
    tmo_limit = 12'd30;
    send_req(1'b0, 'h0, 300, 'hF000, 12);
    fill(128);
    take("R10 partial data", 'h0, 128, 172, 0, 12);
    take("R10 timeout remainder", 'h80, 172, 0, 2, 12);
    fill(100);
    quiet(4, "R10 late fill ignored");
    chk(req_ready == 1'b1, "R10 idle after", int'(req_ready), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule